// File: doc/BRIEF.md
# Bus Ownership Controller with Selectable Release Policy

This block sits on the master side of a shared backplane. A local agent raises a transfer request. The controller asks an external arbiter for the bus and waits for its grant. While it owns the bus it holds a bus-busy line, and it tells the local agent when to start each transfer with a one-cycle go pulse. The local agent reports the end of each transfer with a done pulse.

Two release policies are selectable at run time:
- **Release after each transfer:** the bus is handed back once every transfer completes, so each new transfer must go through the arbiter again.
- **Hold until asked:** the bus stays owned through idle gaps. Later transfers start with no new arbitration. Ownership ends only when a competing master raises bus clear, or when software switches the policy back.

No data moves through this block, so every pin is a plain level or pulse and there is no valid/ready back-pressure. The local request works as a level. It is consumed by the go pulse. If it is high again in the cycle a transfer completes, it counts as a new request.

Top module: `bus_owner_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, bus request, bus busy and go are all low.
- R2: In the idle state, with the release gap expired, a pending local request raises bus request on the next cycle. Bus request stays high until a grant is seen or the local request is withdrawn.
- R3: A grant seen while requesting, with the local request still high, raises bus busy on the next cycle. If the local request has been withdrawn, the controller drops bus request and returns to idle without ever asserting bus busy.
- R4: Go is high for exactly one cycle, the first cycle of each transfer, and only while bus busy is high.
- R5: With policy input 0 (release after each transfer), bus busy falls on the cycle after done. This holds even if a new local request is already pending, and the next transfer waits for a fresh bus request and grant.
- R6: With policy input 1 (hold), a done with no pending request and no clear keeps bus busy high through the idle gap that follows.
- R7: With policy input 1, while the bus is held, a local request starts a transfer on the next cycle with no bus request. A request that is high in the done cycle starts the next transfer directly.
- R8: With policy input 1, bus clear while the bus is held and idle drops bus busy on the next cycle.
- R9: A bus clear that arrives during a transfer is remembered. Bus busy stays high until that transfer's done, then falls on the following cycle. The remembered clear is forgotten once the bus is released.
- R10: After bus busy falls, bus request stays low for GAP_CYCLES+2 cycles, counting the first cycle with busy low. With a local request pending throughout, bus request rises in the cycle after that.
- R11: A grant that arrives while not requesting has no effect: bus busy and go stay low.
- R12: Changing the policy input to 0 while the bus is held and idle releases the bus on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_policy_i | input | 1 | 0 = release after each transfer, 1 = hold until bus clear |
| xfer_req_i | input | 1 | Local transfer request (level) |
| xfer_done_i | input | 1 | Local transfer finished (one-cycle pulse) |
| bus_grant_i | input | 1 | Grant from the external arbiter |
| bus_clear_i | input | 1 | Another master asks for the bus |
| bus_req_o | output | 1 | Request to the arbiter |
| bus_busy_o | output | 1 | This master owns the bus |
| xfer_go_o | output | 1 | Start the next local transfer (one-cycle pulse) |

## Verification
The assertions assume four things about the inputs:
- done is pulsed only while a transfer is in progress, and never in the go cycle itself.
- The local agent withdraws its request after go unless it wants another transfer.
- The grant is meaningful only while bus request is high.
- The policy input changes only between transfers.

The stimulus keeps to these rules. It drops the request the cycle after each go, places every done at least one cycle after its go, and toggles the policy only while the bus is idle or held. Grants and clears are still deliberately sent in states where they must be ignored or remembered.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQUEST = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_HELD    = 3'd3,
    ST_RELEASE = 3'd4
  } own_state_e;

  typedef enum logic {
    POL_EACH = 1'b0,
    POL_HOLD = 1'b1
  } own_policy_e;

  function automatic logic owns_bus(input own_state_e s);
    return (s == ST_ACTIVE) || (s == ST_HELD);
  endfunction

endpackage

// File: rtl/bus_own_gap_timer.sv
module bus_own_gap_timer #(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R10: a load always arms the timer for the configured gap
  p_gap_armed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/bus_own_clear_latch.sv
module bus_own_clear_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic owned_i,
  input  logic clear_i,
  input  logic release_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (release_i) begin
      pend_q <= 1'b0;
    end else if (owned_i && clear_i) begin
      pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R9: a remembered clear never survives a release
  p_clear_forgotten_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !pend_o);

endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       policy_i,
  input  logic       xfer_req_i,
  input  logic       xfer_done_i,
  input  logic       bus_grant_i,
  input  logic       bus_clear_i,
  input  logic       clear_pend_i,
  input  logic       gap_expired_i,
  output own_state_e state_o,
  output logic       go_o
);
  own_state_e state_q, state_d;
  logic       go_q, go_d;
  logic       must_yield;

  assign must_yield = (policy_i == POL_EACH) || clear_pend_i || bus_clear_i;

  always_comb begin
    state_d = state_q;
    go_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (xfer_req_i && gap_expired_i) state_d = ST_REQUEST;
      end
      ST_REQUEST: begin
        if (!xfer_req_i) begin
          state_d = ST_IDLE;
        end else if (bus_grant_i) begin
          state_d = ST_ACTIVE;
          go_d    = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (xfer_done_i) begin
          if (must_yield) begin
            state_d = ST_RELEASE;
          end else if (xfer_req_i) begin
            state_d = ST_ACTIVE;
            go_d    = 1'b1;
          end else begin
            state_d = ST_HELD;
          end
        end
      end
      ST_HELD: begin
        if (must_yield) begin
          state_d = ST_RELEASE;
        end else if (xfer_req_i) begin
          state_d = ST_ACTIVE;
          go_d    = 1'b1;
        end
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
    end
  end

  assign state_o = state_q;
  assign go_o    = go_q;

  // R3: grant with a live request leads into a transfer
  p_grant_starts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQUEST && bus_grant_i && xfer_req_i) |=> (state_q == ST_ACTIVE && go_q));

  // R9: a transfer in flight is never cut short
  p_xfer_finishes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && !xfer_done_i) |=> (state_q == ST_ACTIVE));

  // R5: release-after-each policy lets go on done
  p_each_releases_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && xfer_done_i && policy_i == POL_EACH) |=> (state_q == ST_RELEASE));

  // R6: held bus stays owned with no clear
  p_hold_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && policy_i == POL_HOLD && !bus_clear_i && !clear_pend_i)
      |=> (state_q == ST_HELD || state_q == ST_ACTIVE));

endmodule

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl
  import bus_own_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_policy_i,
  input  logic xfer_req_i,
  input  logic xfer_done_i,
  input  logic bus_grant_i,
  input  logic bus_clear_i,
  output logic bus_req_o,
  output logic bus_busy_o,
  output logic xfer_go_o
);
  own_state_e state;
  logic       go;
  logic       clear_pend;
  logic       gap_expired;

  bus_own_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .policy_i     (hold_policy_i),
    .xfer_req_i   (xfer_req_i),
    .xfer_done_i  (xfer_done_i),
    .bus_grant_i  (bus_grant_i),
    .bus_clear_i  (bus_clear_i),
    .clear_pend_i (clear_pend),
    .gap_expired_i(gap_expired),
    .state_o      (state),
    .go_o         (go)
  );

  bus_own_clear_latch u_clear (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .owned_i  (owns_bus(state)),
    .clear_i  (bus_clear_i),
    .release_i(state == ST_RELEASE),
    .pend_o   (clear_pend)
  );

  bus_own_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (state == ST_RELEASE),
    .tick_i   (state == ST_IDLE),
    .expired_o(gap_expired)
  );

  assign bus_req_o  = (state == ST_REQUEST);
  assign bus_busy_o = owns_bus(state);
  assign xfer_go_o  = go;

  // R4: go only ever fires while owning the bus
  p_go_owned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_go_o |-> bus_busy_o);

  // R10: no request in the cycle right after letting go
  p_gap_after_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_busy_o) |=> !bus_req_o);

  // R11: grant while not requesting leaves ownership untouched
  p_stray_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && !bus_busy_o && bus_grant_i) |=> !bus_busy_o);

endmodule

// File: tb/test_bus_owner_ctrl.sv
`timescale 1ns/1ps
module test_bus_owner_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b0, lreq = 1'b0, done = 1'b0, gnt = 1'b0, clr = 1'b0;
  logic bus_req, bus_busy, go;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [2:0] exp_q[$];
  bit         chk_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  bus_owner_ctrl i_bus_owner_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hold_policy_i(pol),
    .xfer_req_i   (lreq),
    .xfer_done_i  (done),
    .bus_grant_i  (gnt),
    .bus_clear_i  (clr),
    .bus_req_o    (bus_req),
    .bus_busy_o   (bus_busy),
    .xfer_go_o    (go)
  );

  // Driver: set inputs before an edge, queue the outputs expected after it
  task automatic step(input logic p, input logic l, input logic d, input logic g,
                      input logic c, input logic [2:0] e, input string tag);
    @(negedge clk);
    pol = p; lreq = l; done = d; gnt = g; clr = c;
    exp_q.push_back(e);
    chk_q.push_back(1'b1);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare {bus_req, bus_busy, go} shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        bit c;
        string t;
        e = exp_q.pop_front();
        c = chk_q.pop_front();
        t = tag_q.pop_front();
        if (c) begin
          checks++;
          if ({bus_req, bus_busy, go} !== e) begin
            fails++;
            $display("FAIL %s: req/busy/go actual %b expected %b at %0t",
                     t, {bus_req, bus_busy, go}, e, $time);
          end
        end
      end
    end
  end

  initial begin
    // R1: reset state
    step(0,0,0,0,0, 3'b000, "R1");
    step(0,1,0,1,0, 3'b000, "R1");
    step(0,1,0,1,1, 3'b000, "R1");
    @(negedge clk); pol = 0; lreq = 0; done = 0; gnt = 0; clr = 0; rst_n = 1'b1;
    step(0,0,0,0,0, 3'b000, "R1");
    // Release-after-each policy
    step(0,1,0,0,0, 3'b100, "R2");
    step(0,1,0,0,0, 3'b100, "R2");
    step(0,1,0,1,0, 3'b011, "R3");
    step(0,0,0,0,0, 3'b010, "R4");
    step(0,0,1,0,0, 3'b000, "R5");
    step(0,1,0,0,0, 3'b000, "R10");
    step(0,1,0,0,0, 3'b000, "R10");
    step(0,1,0,0,0, 3'b100, "R10");
    step(0,1,0,1,0, 3'b011, "R4");
    step(0,0,0,0,0, 3'b010, "R4");
    step(0,1,1,0,0, 3'b000, "R5");
    step(0,1,0,0,0, 3'b000, "R5");
    step(0,1,0,0,0, 3'b000, "R5");
    step(0,1,0,0,0, 3'b100, "R5");
    step(0,0,0,0,0, 3'b000, "R3");
    step(0,0,0,1,0, 3'b000, "R11");
    step(0,0,0,1,0, 3'b000, "R11");
    step(0,1,0,0,0, 3'b100, "R2");
    step(0,0,0,1,0, 3'b000, "R3");
    // Hold policy
    step(1,1,0,0,0, 3'b100, "R2");
    step(1,1,0,1,0, 3'b011, "R3");
    step(1,0,0,0,0, 3'b010, "R4");
    step(1,0,1,0,0, 3'b010, "R6");
    step(1,0,0,0,0, 3'b010, "R6");
    step(1,0,0,1,0, 3'b010, "R6");
    step(1,0,0,0,0, 3'b010, "R6");
    step(1,1,0,0,0, 3'b011, "R7");
    step(1,0,0,0,0, 3'b010, "R7");
    step(1,1,1,0,0, 3'b011, "R7");
    step(1,0,0,0,0, 3'b010, "R7");
    step(1,0,0,0,1, 3'b010, "R9");
    step(1,0,0,0,0, 3'b010, "R9");
    step(1,0,1,0,0, 3'b000, "R9");
    step(1,0,0,0,0, 3'b000, "R9");
    // Clear while held and idle
    step(1,1,0,0,0, 3'b000, "R10");
    step(1,1,0,0,0, 3'b100, "R10");
    step(1,1,0,1,0, 3'b011, "R3");
    step(1,0,0,0,0, 3'b010, "R4");
    step(1,0,1,0,0, 3'b010, "R9");
    step(1,0,0,0,1, 3'b000, "R8");
    step(1,0,0,0,0, 3'b000, "R8");
    // Policy change while held
    step(1,1,0,0,0, 3'b000, "R10");
    step(1,1,0,0,0, 3'b100, "R2");
    step(1,1,0,1,0, 3'b011, "R3");
    step(1,0,0,0,0, 3'b010, "R4");
    step(1,0,1,0,0, 3'b010, "R6");
    step(1,0,0,0,0, 3'b010, "R6");
    step(0,0,0,0,0, 3'b000, "R12");
    step(0,0,0,0,0, 3'b000, "R12");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule